// File: doc/BRIEF.md
# Luma Edge Deblocking Decision Unit

This block takes one luma edge segment of eight lines and decides how the edge should be deblocked. Each line carries eight samples straddling the edge: four on the P side (P3 farthest, P0 nearest) and four on the Q side (Q0 nearest, Q3 farthest). The segment is treated as two independent halves of four lines each (lines 0–3 and lines 4–7). Each half has its own clipping threshold tc, and one edge threshold beta is shared by both halves.

For each half the unit reports whether the edge is filtered at all, whether the strong or the weak filter applies, and, for the weak filter, whether the second sample on the P side and on the Q side may also be modified. All of these decisions look only at the first and last line of each half. Thresholds are given at 8-bit scale and are rescaled internally for 10-bit and 12-bit content. The sample arithmetic of the filter itself is done elsewhere. This unit only produces the decision flags, two cycles after the inputs are strobed.

Top module: `luma_dbk_decider`

## Requirements
- R1: After reset, out_valid and every decision flag are 0.
- R2: A cycle with in_valid high produces exactly one cycle of out_valid high, two clock cycles later. Strobes on consecutive cycles give results on consecutive cycles, and no result appears without a strobe.
- R3: beta and both tc values are shifted left by 0, 2 or 4 bits when depth_sel is 0 (8-bit), 1 (10-bit) or 2 (12-bit). Code 3 behaves like code 2.
- R4: For line n, dp = |P2 − 2·P1 + P0| and dq = |Q2 − 2·Q1 + Q0|, with d = dp + dq. A half is filtered (out_filt bit = 1) only when d of its first line plus d of its last line is less than the scaled beta. Otherwise all four of its flags are 0.
- R5: A filtered half uses the strong filter (out_strong bit = 1) only when both its first and last lines satisfy all three of 2·d < beta>>2, |P3−P0| + |Q3−Q0| < beta>>3, and |P0−Q0| < (5·tc + 1)>>1.
- R6: The strong-filter step test of each half uses that half's own scaled tc (tc_lo for lines 0–3, tc_hi for lines 4–7).
- R7: For a filtered half that is not strong, the out_weak_p bit is 1 when dp(first) + dp(last) < (beta + (beta>>1))>>3, and the out_weak_q bit follows the same rule on dq. Both bits are 0 for strong or skipped halves.
- R8: The samples of lines 1, 2, 5 and 6 have no effect on any output.
- R9: Between results (out_valid low) every decision output holds its last value.
- R10: The halves are decided independently, so every combination of strong and weak across the two halves is reported.

In each 2-bit output, bit 0 is the half of lines 0–3 and bit 1 is the half of lines 4–7. Sample k (0..7 = P3, P2, P1, P0, Q0, Q1, Q2, Q3) of line n occupies lines_in[(8·n + k)·SAMP_W +: SAMP_W]. Samples below 12 bits sit in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: capture the segment this cycle |
| depth_sel | input | 2 | Sample depth code: 0 = 8, 1 = 10, 2 or 3 = 12 bits |
| beta_in | input | BETA_W (7) | Edge threshold at 8-bit scale |
| tc_lo | input | TC_W (5) | Clipping threshold for lines 0–3 at 8-bit scale |
| tc_hi | input | TC_W (5) | Clipping threshold for lines 4–7 at 8-bit scale |
| lines_in | input | 64·SAMP_W (768) | Eight lines of eight samples |
| out_valid | output | 1 | Decision flags are new this cycle |
| out_filt | output | 2 | Per half: filter the edge |
| out_strong | output | 2 | Per half: use the strong filter |
| out_weak_p | output | 2 | Per half: weak filter may modify the second P sample |
| out_weak_q | output | 2 | Per half: weak filter may modify the second Q sample |

## Verification
The bench builds the unit with its default widths: 12-bit samples, 16-bit metrics, 7-bit beta and 5-bit tc. These widths admit every depth code, so one build covers the 8-, 10- and 12-bit threshold scaling. The largest metric sums, such as full-swing 12-bit second differences on both lines of a half, also fit in the 16-bit datapath. The same build lets the directed tests place equality cases exactly on the skip and side-flag thresholds. It also lets tc_lo and tc_hi differ so that the two halves take different strong/weak outcomes. Randomised segments at all depths are then compared with an independent model of the rules.

// File: rtl/luma_dbk_pkg.sv
package luma_dbk_pkg;
    localparam int LINES_PER_SEG = 8;
    localparam int TAPS_PER_LINE = 8;
    localparam int HALVES        = 2;
    localparam int USED_LINES    = 2 * HALVES;

    // Threshold shift for a depth code: 8 -> 0, 10 -> 2, 12 -> 4.
    function automatic logic [2:0] depth_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd0;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Map a stored line slot to its segment line: the first and last line of each half.
    function automatic int slot_line(input int slot);
        return (slot / 2) * 4 + (slot % 2) * 3;
    endfunction
endpackage

// File: rtl/luma_line_metrics.sv
module luma_line_metrics #(
    parameter int SAMP_W = 12,
    parameter int MET_W  = 16
) (
    input  logic [8*SAMP_W-1:0] taps_i,
    output logic [MET_W-1:0]    dp_o,
    output logic [MET_W-1:0]    dq_o,
    output logic [MET_W-1:0]    flat_o,
    output logic [MET_W-1:0]    step_o
);
    localparam int PAD = MET_W - SAMP_W;

    logic [MET_W-1:0] tap [8];

    for (genvar k = 0; k < 8; k++) begin : g_tap
        assign tap[k] = {{PAD{1'b0}}, taps_i[k*SAMP_W +: SAMP_W]};
    end

    function automatic logic [MET_W-1:0] adiff(input logic [MET_W-1:0] a,
                                               input logic [MET_W-1:0] b);
        return (a >= b) ? a - b : b - a;
    endfunction

    logic [MET_W-1:0] p_outer, q_outer;
    assign p_outer = tap[1] + tap[3];
    assign q_outer = tap[6] + tap[4];

    assign dp_o   = adiff(p_outer, tap[2] << 1);
    assign dq_o   = adiff(q_outer, tap[5] << 1);
    assign flat_o = adiff(tap[0], tap[3]) + adiff(tap[7], tap[4]);
    assign step_o = adiff(tap[3], tap[4]);
endmodule

// File: rtl/luma_half_decide.sv
module luma_half_decide #(
    parameter int MET_W = 16
) (
    input  logic [MET_W-1:0] dp_a_i,
    input  logic [MET_W-1:0] dq_a_i,
    input  logic [MET_W-1:0] flat_a_i,
    input  logic [MET_W-1:0] step_a_i,
    input  logic [MET_W-1:0] dp_b_i,
    input  logic [MET_W-1:0] dq_b_i,
    input  logic [MET_W-1:0] flat_b_i,
    input  logic [MET_W-1:0] step_b_i,
    input  logic [MET_W-1:0] beta_i,
    input  logic [MET_W-1:0] tc_i,
    output logic             filt_o,
    output logic             strong_o,
    output logic             weak_p_o,
    output logic             weak_q_o
);
    logic [MET_W-1:0] act_a, act_b, tc_x5, tc25, side_lim;
    logic             ok_a, ok_b;

    assign act_a    = dp_a_i + dq_a_i;
    assign act_b    = dp_b_i + dq_b_i;
    assign tc_x5    = (tc_i << 2) + tc_i + {{(MET_W-1){1'b0}}, 1'b1};
    assign tc25     = tc_x5 >> 1;
    assign side_lim = (beta_i + (beta_i >> 1)) >> 3;

    assign ok_a = ((act_a << 1) < (beta_i >> 2)) && (flat_a_i < (beta_i >> 3)) && (step_a_i < tc25);
    assign ok_b = ((act_b << 1) < (beta_i >> 2)) && (flat_b_i < (beta_i >> 3)) && (step_b_i < tc25);

    assign filt_o   = (act_a + act_b) < beta_i;
    assign strong_o = filt_o && ok_a && ok_b;
    assign weak_p_o = filt_o && !strong_o && ((dp_a_i + dp_b_i) < side_lim);
    assign weak_q_o = filt_o && !strong_o && ((dq_a_i + dq_b_i) < side_lim);
endmodule

// File: rtl/luma_dbk_decider.sv
module luma_dbk_decider
    import luma_dbk_pkg::*;
#(
    parameter int SAMP_W = 12,
    parameter int BETA_W = 7,
    parameter int TC_W   = 5,
    parameter int MET_W  = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_valid,
    input  logic [1:0]                               depth_sel,
    input  logic [BETA_W-1:0]                        beta_in,
    input  logic [TC_W-1:0]                          tc_lo,
    input  logic [TC_W-1:0]                          tc_hi,
    input  logic [LINES_PER_SEG*TAPS_PER_LINE*SAMP_W-1:0] lines_in,
    output logic                                     out_valid,
    output logic [1:0]                               out_filt,
    output logic [1:0]                               out_strong,
    output logic [1:0]                               out_weak_p,
    output logic [1:0]                               out_weak_q
);
    localparam int LINE_W = TAPS_PER_LINE * SAMP_W;

    typedef struct packed {
        logic                                s1_vld;
        logic [USED_LINES-1:0][LINE_W-1:0]   s1_lines;
        logic [MET_W-1:0]                    s1_beta;
        logic [HALVES-1:0][MET_W-1:0]        s1_tc;
        logic                                o_vld;
        logic [HALVES-1:0]                   o_filt;
        logic [HALVES-1:0]                   o_strong;
        logic [HALVES-1:0]                   o_wp;
        logic [HALVES-1:0]                   o_wq;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [MET_W-1:0] m_dp [USED_LINES];
    logic [MET_W-1:0] m_dq [USED_LINES];
    logic [MET_W-1:0] m_flat [USED_LINES];
    logic [MET_W-1:0] m_step [USED_LINES];
    logic [HALVES-1:0] h_filt, h_strong, h_wp, h_wq;

    for (genvar g = 0; g < USED_LINES; g++) begin : g_line
        luma_line_metrics #(.SAMP_W(SAMP_W), .MET_W(MET_W)) u_met (
            .taps_i (st_q.s1_lines[g]),
            .dp_o   (m_dp[g]),
            .dq_o   (m_dq[g]),
            .flat_o (m_flat[g]),
            .step_o (m_step[g])
        );
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        luma_half_decide #(.MET_W(MET_W)) u_dec (
            .dp_a_i   (m_dp[2*h]),
            .dq_a_i   (m_dq[2*h]),
            .flat_a_i (m_flat[2*h]),
            .step_a_i (m_step[2*h]),
            .dp_b_i   (m_dp[2*h+1]),
            .dq_b_i   (m_dq[2*h+1]),
            .flat_b_i (m_flat[2*h+1]),
            .step_b_i (m_step[2*h+1]),
            .beta_i   (st_q.s1_beta),
            .tc_i     (st_q.s1_tc[h]),
            .filt_o   (h_filt[h]),
            .strong_o (h_strong[h]),
            .weak_p_o (h_wp[h]),
            .weak_q_o (h_wq[h])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = in_valid;
        if (in_valid) begin
            for (int j = 0; j < USED_LINES; j++) begin
                st_d.s1_lines[j] = lines_in[slot_line(j)*LINE_W +: LINE_W];
            end
            st_d.s1_beta  = MET_W'(beta_in) << depth_shift(depth_sel);
            st_d.s1_tc[0] = MET_W'(tc_lo) << depth_shift(depth_sel);
            st_d.s1_tc[1] = MET_W'(tc_hi) << depth_shift(depth_sel);
        end
        st_d.o_vld = st_q.s1_vld;
        if (st_q.s1_vld) begin
            st_d.o_filt   = h_filt;
            st_d.o_strong = h_strong;
            st_d.o_wp     = h_wp;
            st_d.o_wq     = h_wq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.o_vld;
    assign out_filt   = st_q.o_filt;
    assign out_strong = st_q.o_strong;
    assign out_weak_p = st_q.o_wp;
    assign out_weak_q = st_q.o_wq;

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);
    a_r4_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (~out_filt & (out_strong | out_weak_p | out_weak_q)) == 2'b00);
    a_r7_side_only_weak: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strong & (out_weak_p | out_weak_q)) == 2'b00);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_filt) && $stable(out_strong) &&
                        $stable(out_weak_p) && $stable(out_weak_q)));
endmodule

// File: tb/luma_dbk_decider_tb_top.sv
module luma_dbk_decider_tb_top;
    localparam int SW = 12;
    localparam int LW = 8 * SW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [1:0]     depth_sel = 2'd0;
    logic [6:0]     beta_in = '0;
    logic [4:0]     tc_lo = '0, tc_hi = '0;
    logic [8*LW-1:0] lines_in = '0;
    logic           out_valid;
    logic [1:0]     out_filt, out_strong, out_weak_p, out_weak_q;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    luma_dbk_decider dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .depth_sel(depth_sel),
        .beta_in(beta_in), .tc_lo(tc_lo), .tc_hi(tc_hi), .lines_in(lines_in),
        .out_valid(out_valid), .out_filt(out_filt), .out_strong(out_strong),
        .out_weak_p(out_weak_p), .out_weak_q(out_weak_q)
    );

    function automatic logic [LW-1:0] mk(input int p3, p2, p1, p0, q0, q1, q2, q3);
        logic [LW-1:0] r;
        r = {SW'(q3), SW'(q2), SW'(q1), SW'(q0), SW'(p0), SW'(p1), SW'(p2), SW'(p3)};
        return r;
    endfunction

    function automatic int px(input logic [8*LW-1:0] L, input int ln, input int k);
        return int'(L[(ln*8+k)*SW +: SW]);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference of the decision rules; result packed {wq, wp, strong, filt}.
    function automatic logic [7:0] model(input logic [8*LW-1:0] L, input int code,
                                         input int beta, input int tlo, input int thi);
        int sh, b, t, dp[2], dq[2], fl[2], st[2];
        logic [1:0] f, s, wp, wq;
        sh = (code == 0) ? 0 : (code == 1) ? 2 : 4;
        b  = beta << sh;
        for (int h = 0; h < 2; h++) begin
            t = ((h == 0) ? tlo : thi) << sh;
            for (int i = 0; i < 2; i++) begin
                int ln = 4*h + 3*i;
                dp[i] = iabs(px(L,ln,1) - 2*px(L,ln,2) + px(L,ln,3));
                dq[i] = iabs(px(L,ln,6) - 2*px(L,ln,5) + px(L,ln,4));
                fl[i] = iabs(px(L,ln,0) - px(L,ln,3)) + iabs(px(L,ln,7) - px(L,ln,4));
                st[i] = iabs(px(L,ln,3) - px(L,ln,4));
            end
            f[h] = (dp[0]+dq[0]+dp[1]+dq[1]) < b;
            s[h] = f[h];
            for (int i = 0; i < 2; i++)
                if (!(2*(dp[i]+dq[i]) < (b >> 2) && fl[i] < (b >> 3) && st[i] < ((5*t+1) >> 1)))
                    s[h] = 1'b0;
            wp[h] = f[h] && !s[h] && ((dp[0]+dp[1]) < ((b + (b >> 1)) >> 3));
            wq[h] = f[h] && !s[h] && ((dq[0]+dq[1]) < ((b + (b >> 1)) >> 3));
        end
        return {wq, wp, s, f};
    endfunction

    task automatic check(input string tag, input logic vld, input logic [7:0] exp);
        logic [7:0] got;
        got = {out_weak_q, out_weak_p, out_strong, out_filt};
        n_checks++;
        if (out_valid !== vld || got !== exp) begin
            n_errors++;
            $display("FAIL %s: valid=%b flags=%b expected valid=%b flags=%b",
                     tag, out_valid, got, vld, exp);
        end
    endtask

    task automatic drive(input logic [8*LW-1:0] L, input int code, input int beta,
                         input int tlo, input int thi);
        lines_in  = L;
        depth_sel = 2'(code);
        beta_in   = 7'(beta);
        tc_lo     = 5'(tlo);
        tc_hi     = 5'(thi);
        in_valid  = 1'b1;
    endtask

    // Strobe once at a falling edge, check two rising edges later, then check the single pulse.
    task automatic run(input string tag, input logic [8*LW-1:0] L, input int code,
                       input int beta, input int tlo, input int thi, input logic [7:0] exp);
        @(negedge clk);
        drive(L, code, beta, tlo, thi);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(tag, 1'b1, exp);
        @(negedge clk);
        check({tag, " R2 single pulse"}, 1'b0, exp);
    endtask

    task automatic t_reset;
        check("R1 reset state", 1'b0, 8'h00);
    endtask

    task automatic t_basic;
        logic [8*LW-1:0] L;
        L = {8{mk(50,50,50,50,50,50,50,50)}};
        run("R5 flat strong", L, 0, 30, 5, 5, 8'b00_00_11_11);
        L = {8{mk(100,100,100,100,120,120,120,120)}};
        run("R7 step weak both sides", L, 0, 30, 2, 2, 8'b11_11_00_11);
        L = {8{mk(100,100,0,100,50,50,50,50)}};
        run("R4 textured skip", L, 0, 30, 5, 5, 8'h00);
    endtask

    task automatic t_strong_lines;
        logic [8*LW-1:0] L;
        L = {8{mk(54,50,50,50,50,50,50,50)}};
        run("R5 flatness fails all lines", L, 0, 30, 5, 5, 8'b11_11_00_11);
        L = {8{mk(50,50,50,50,50,50,50,50)}};
        L[7*LW +: LW] = mk(54,50,50,50,50,50,50,50);
        run("R5 last line of upper half fails", L, 0, 30, 5, 5, 8'b10_10_01_11);
    endtask

    task automatic t_halves;
        logic [8*LW-1:0] L;
        L = {8{mk(100,100,100,100,103,103,103,103)}};
        run("R6 R10 strong/weak", L, 0, 30, 10, 0, 8'b10_10_01_11);
        run("R6 R10 weak/strong", L, 0, 30, 0, 10, 8'b01_01_10_11);
        run("R10 strong/strong", L, 0, 30, 10, 10, 8'b00_00_11_11);
        run("R10 weak/weak", L, 0, 30, 0, 0, 8'b11_11_00_11);
    endtask

    task automatic t_ignore;
        logic [8*LW-1:0] L;
        L = {8{mk(50,50,50,50,50,50,50,50)}};
        foreach (L[i]) begin end
        L[1*LW +: LW] = mk(0,4000,0,4000,0,4000,0,4000);
        L[2*LW +: LW] = mk(4095,0,4095,9,3000,0,3000,7);
        L[5*LW +: LW] = mk(0,4000,0,4000,0,4000,0,4000);
        L[6*LW +: LW] = mk(4095,0,4095,9,3000,0,3000,7);
        run("R8 middle lines ignored", L, 0, 30, 5, 5, 8'b00_00_11_11);
    endtask

    task automatic t_boundaries;
        logic [8*LW-1:0] L;
        // dp = 4 on every line, dq = 0: sum over a half is 8
        L = {8{mk(60,60,58,60,60,60,60,60)}};
        run("R4 sum equals beta skips", L, 0, 8, 5, 5, 8'h00);
        run("R4 sum below beta filters", L, 0, 9, 5, 5, 8'b11_00_00_11);
        // beta 64: side limit 12. dp 6+6=12 fails, dq 4+4=8 passes
        L = {8{mk(60,60,57,60,60,58,60,60)}};
        run("R7 side sum equals limit", L, 0, 64, 5, 5, 8'b11_00_00_11);
        // last line of each half: dp 5 via P2 so dp sum 11 passes
        L[3*LW +: LW] = mk(60,65,60,60,60,58,60,60);
        L[7*LW +: LW] = mk(60,65,60,60,60,58,60,60);
        run("R7 side sum below limit", L, 0, 64, 5, 5, 8'b11_11_00_11);
    endtask

    task automatic t_depth;
        logic [8*LW-1:0] L;
        L = {8{mk(400,400,400,400,412,412,412,412)}};
        run("R3 10-bit tc scaling strong", L, 1, 30, 2, 2, 8'b00_00_11_11);
        run("R3 same samples at 8-bit weak", L, 0, 30, 2, 2, 8'b11_11_00_11);
        L = {8{mk(1600,1600,1600,1600,1650,1650,1650,1650)}};
        run("R3 12-bit strong", L, 2, 30, 2, 2, 8'b00_00_11_11);
        run("R3 code 3 acts as 12-bit", L, 3, 30, 2, 2, 8'b00_00_11_11);
        run("R3 same samples at 10-bit weak", L, 1, 30, 2, 2, 8'b11_11_00_11);
        // beta 10 at 10-bit -> 40; dp 20 per line gives 40 -> skip, dp 18 -> filter
        L = {8{mk(400,400,390,400,400,400,400,400)}};
        run("R3 R4 scaled beta equal skips", L, 1, 10, 2, 2, 8'h00);
        L = {8{mk(400,400,391,400,400,400,400,400)}};
        run("R3 R4 scaled beta below filters", L, 1, 10, 2, 2, 8'b11_00_00_11);
    endtask

    task automatic t_back_to_back;
        logic [8*LW-1:0] a, b;
        a = {8{mk(50,50,50,50,50,50,50,50)}};
        b = {8{mk(100,100,0,100,50,50,50,50)}};
        @(negedge clk);
        drive(a, 0, 30, 5, 5);
        @(negedge clk);
        drive(b, 0, 30, 5, 5);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 first of back-to-back", 1'b1, 8'b00_00_11_11);
        @(negedge clk);
        check("R2 second of back-to-back", 1'b1, 8'h00);
        @(negedge clk);
        check("R2 back-to-back ends", 1'b0, 8'h00);
    endtask

    task automatic t_hold;
        logic [8*LW-1:0] L;
        L = {8{mk(100,100,100,100,103,103,103,103)}};
        run("R9 setup result", L, 0, 30, 10, 0, 8'b10_10_01_11);
        lines_in = {8{mk(100,100,0,100,50,50,50,50)}};
        beta_in  = 7'd1;
        repeat (3) @(negedge clk);
        check("R9 outputs hold without strobe", 1'b0, 8'b10_10_01_11);
    endtask

    task automatic t_random;
        for (int n = 0; n < 300; n++) begin
            logic [8*LW-1:0] L;
            int code, sh, base, amp, beta, tlo, thi;
            code = $urandom_range(0, 3);
            sh   = (code == 0) ? 0 : (code == 1) ? 2 : 4;
            base = $urandom_range(64, (1 << (8 + sh)) - 65);
            amp  = $urandom_range(0, 4 << sh);
            for (int i = 0; i < 64; i++)
                L[i*SW +: SW] = SW'(base + $urandom_range(0, 2*amp) - amp);
            beta = $urandom_range(0, 64);
            tlo  = $urandom_range(0, 24);
            thi  = $urandom_range(0, 24);
            run("R4 R5 R7 R10 random segment", L, code, beta, tlo, thi,
                model(L, code, beta, tlo, thi));
        end
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: valid=%b expected run to finish", out_valid);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_strong_lines();
        t_halves();
        t_ignore();
        t_boundaries();
        t_depth();
        t_back_to_back();
        t_hold();
        t_random();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule